// File: doc/BRIEF.md
# Processor Packet Buffer Handshake Controller

This block sits between a processor and a word-wide packet path. A single line-organised buffer RAM holds one packet at a time. The receive side writes an incoming valid/ready/last stream into the buffer. The transmit side reads a commanded number of lines back out as an outgoing valid/ready/last stream. Each side runs its own four-state machine: idle, busy, done and error.

Software drives both sides through one write-only control word and watches them through a registered status word. Each side follows a fixed cycle. The processor writes a start bit, waits for done or error, writes the clear bit, and waits for idle before it starts again. Line counts travel in the upper half-word: the processor reads the received length from status, and it supplies the transmit length in the same control write as the transmit start.

The processor reaches the buffer through a request/grant port. One RAM port is shared under fixed per-cycle priority: a receive beat first, then a transmit fetch, then the processor.

Top module: `pktbuf_hs`

## Requirements
- R1: After reset, status reads 0x0000_0040. The receive side is armed with in_ready high, the transmit side is idle, and out_valid is low.
- R2: Control bits: bit 0 clears receive, bit 1 starts receive, bit 2 clears transmit, bit 3 starts transmit, and bits [31:16] carry the transmit line count. Status bits: 0 receive done, 1 receive error, 2 receive idle, 4 transmit done, 5 transmit error, 6 transmit idle.
- R3: An armed receive side stores accepted beats at lines 0, 1, 2 and so on. On the beat with in_last it sets status bit 0 and puts the line count in status [31:16]. Those bits read zero whenever bit 0 is clear.
- R4: A beat accepted while DEPTH lines are already held is discarded and sets receive error (status bit 1). in_ready then stays low until the side is cleared and started again.
- R5: Done and error hold until the matching clear bit is written. A clear then moves the side to idle.
- R6: A start bit is ignored while its side is not idle, and a clear bit has no effect while its side is idle.
- R7: A transmit start with count N (1..DEPTH) sends lines 0..N-1 in order with out_last on line N-1 only, and then sets status bit 4.
- R8: A transmit start with count 0 or a count above DEPTH sets status bit 5 and sends nothing.
- R9: The buffer port goes to an accepted receive beat first, then to a transmit fetch, and only then to the processor. cpu_buf_gnt stays low in any cycle a stream uses the port. Read data appears on cpu_buf_rdata in the cycle after a granted read.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| status_q | output | 32 | Registered status word |
| cpu_buf_req | input | 1 | Processor buffer access request |
| cpu_buf_we | input | 1 | Processor access is a write |
| cpu_buf_addr | input | AW | Processor buffer line |
| cpu_buf_wdata | input | DW | Processor write data |
| cpu_buf_gnt | output | 1 | Processor access performed this cycle |
| cpu_buf_rdata | output | DW | Buffer read data, one cycle after grant |
| in_valid | input | 1 | Incoming beat valid |
| in_data | input | DW | Incoming beat data |
| in_last | input | 1 | Incoming beat ends packet |
| in_ready | output | 1 | Receive side accepts beats |
| out_valid | output | 1 | Outgoing beat valid |
| out_data | output | DW | Outgoing beat data |
| out_last | output | 1 | Outgoing beat is final line |
| out_ready | input | 1 | Downstream accepts beat |

## Verification
The receive path is tried with three patterns. A short packet that ends on last checks the stored lines and the reported length. An endless packet longer than the buffer shows where overflow triggers and that in_ready falls. A one-beat packet issued in the same cycle as a processor read separates the port priorities. The transmit path runs an eight-line packet under a repeating ready/stall pattern, which exposes ordering errors, a misplaced last and data that changes under backpressure. Zero and over-depth counts confirm that the error path sends nothing. Repeated start and clear writes in the done and idle states show which control writes are ignored.

// File: rtl/pbh_pkg.sv
package pbh_pkg;

  typedef enum logic [1:0] {
    SIDE_IDLE = 2'd0,
    SIDE_BUSY = 2'd1,
    SIDE_DONE = 2'd2,
    SIDE_ERR  = 2'd3
  } side_state_e;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_LOAD  = 2'd1,
    PH_HOLD  = 2'd2
  } tx_phase_e;

  // control word bit positions (software-visible)
  localparam int unsigned CTL_RX_CLR = 0;
  localparam int unsigned CTL_RX_GO  = 1;
  localparam int unsigned CTL_TX_CLR = 2;
  localparam int unsigned CTL_TX_GO  = 3;

  // status word bit positions (software-visible)
  localparam int unsigned ST_RX_DONE = 0;
  localparam int unsigned ST_RX_ERR  = 1;
  localparam int unsigned ST_RX_IDLE = 2;
  localparam int unsigned ST_TX_DONE = 4;
  localparam int unsigned ST_TX_ERR  = 5;
  localparam int unsigned ST_TX_IDLE = 6;

  localparam int unsigned LEN_W   = 16;
  localparam int unsigned LEN_LSB = 16;

endpackage

// File: rtl/pbh_buf_ram.sv
module pbh_buf_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // single port, registered read: maps onto one block RAM port
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/pbh_rx_side.sv
module pbh_rx_side
  import pbh_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          go_i,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output side_state_e   state_o,
  output logic [CW-1:0] len_o
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  side_state_e   state;
  logic [CW-1:0] cnt;
  logic          beat;
  logic          full;

  assign in_ready = (state == SIDE_BUSY);
  assign beat     = in_valid && in_ready;
  assign full     = (cnt == FULL);
  assign wr_en    = beat && !full;
  assign wr_addr  = cnt[AW-1:0];
  assign wr_data  = in_data;
  assign state_o  = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SIDE_BUSY;          // armed out of reset
      cnt   <= '0;
      len_o <= '0;
    end else begin
      unique case (state)
        SIDE_IDLE: if (go_i) begin
          state <= SIDE_BUSY;
          cnt   <= '0;
          len_o <= '0;
        end
        SIDE_BUSY: begin
          if (clr_i) begin
            state <= SIDE_IDLE;
          end else if (beat) begin
            if (full) begin
              state <= SIDE_ERR;
              len_o <= '0;
            end else if (in_last) begin
              state <= SIDE_DONE;
              len_o <= cnt + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        SIDE_DONE, SIDE_ERR: if (clr_i) begin
          state <= SIDE_IDLE;
          cnt   <= '0;
          len_o <= '0;
        end
        default: state <= SIDE_IDLE;
      endcase
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == SIDE_DONE && !clr_i) |=> (state == SIDE_DONE && $stable(len_o)));

  p_err_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (state == SIDE_ERR) |-> !wr_en);

endmodule

// File: rtl/pbh_tx_side.sv
module pbh_tx_side
  import pbh_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int LW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          go_i,
  input  logic [LW-1:0] go_len_i,
  output logic          rd_req,
  input  logic          rd_gnt,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          out_ready,
  output side_state_e   state_o
);

  side_state_e   state;
  tx_phase_e     phase;
  logic [CW-1:0] idx;
  logic [CW-1:0] total;
  logic          bad_len;

  assign bad_len = (go_len_i == '0) || (go_len_i > LW'(DEPTH));
  assign rd_req  = (state == SIDE_BUSY) && (phase == PH_FETCH);
  assign rd_addr = idx[AW-1:0];
  assign state_o = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SIDE_IDLE;
      phase     <= PH_FETCH;
      idx       <= '0;
      total     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      unique case (state)
        SIDE_IDLE: if (go_i) begin
          phase <= PH_FETCH;
          idx   <= '0;
          if (bad_len) begin
            state <= SIDE_ERR;
            total <= '0;
          end else begin
            state <= SIDE_BUSY;
            total <= go_len_i[CW-1:0];
          end
        end
        SIDE_BUSY: begin
          if (clr_i) begin
            state     <= SIDE_IDLE;
            phase     <= PH_FETCH;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
          end else begin
            unique case (phase)
              PH_FETCH: if (rd_gnt) phase <= PH_LOAD;
              PH_LOAD: begin
                out_data  <= rd_data;
                out_valid <= 1'b1;
                out_last  <= (idx == total - 1'b1);
                phase     <= PH_HOLD;
              end
              PH_HOLD: if (out_ready) begin
                out_valid <= 1'b0;
                out_last  <= 1'b0;
                phase     <= PH_FETCH;
                if (out_last) state <= SIDE_DONE;
                else          idx   <= idx + 1'b1;
              end
              default: phase <= PH_FETCH;
            endcase
          end
        end
        SIDE_DONE, SIDE_ERR: if (clr_i) state <= SIDE_IDLE;
        default: state <= SIDE_IDLE;
      endcase
    end
  end

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr_i) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (state != SIDE_IDLE && go_i && !clr_i) |=> $stable(total));

  p_valid_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (state == SIDE_BUSY));

  p_err_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (state == SIDE_ERR) |-> (!out_valid && !rd_req));

endmodule

// File: rtl/pktbuf_hs.sv
module pktbuf_hs
  import pbh_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [31:0]   ctrl_wdata,
  output logic [31:0]   status_q,
  input  logic          cpu_buf_req,
  input  logic          cpu_buf_we,
  input  logic [AW-1:0] cpu_buf_addr,
  input  logic [DW-1:0] cpu_buf_wdata,
  output logic          cpu_buf_gnt,
  output logic [DW-1:0] cpu_buf_rdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          out_ready
);

  // control decode
  logic            rx_clr, rx_go, tx_clr, tx_go;
  logic [LEN_W-1:0] tx_len;
  logic [11:0]     ctrl_unused;

  assign rx_clr      = ctrl_wr && ctrl_wdata[CTL_RX_CLR];
  assign rx_go       = ctrl_wr && ctrl_wdata[CTL_RX_GO];
  assign tx_clr      = ctrl_wr && ctrl_wdata[CTL_TX_CLR];
  assign tx_go       = ctrl_wr && ctrl_wdata[CTL_TX_GO];
  assign tx_len      = ctrl_wdata[LEN_LSB +: LEN_W];
  assign ctrl_unused = ctrl_wdata[15:4];

  // side instances
  side_state_e   rx_state, tx_state;
  logic [CW-1:0] rx_len;
  logic          rx_wr;
  logic [AW-1:0] rx_addr;
  logic [DW-1:0] rx_data;
  logic          tx_req, tx_gnt;
  logic [AW-1:0] tx_addr;
  logic [DW-1:0] ram_rdata;

  pbh_rx_side #(.DW(DW), .DEPTH(DEPTH)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (rx_clr),
    .go_i     (rx_go),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .wr_en    (rx_wr),
    .wr_addr  (rx_addr),
    .wr_data  (rx_data),
    .state_o  (rx_state),
    .len_o    (rx_len)
  );

  pbh_tx_side #(.DW(DW), .DEPTH(DEPTH), .LW(LEN_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (tx_clr),
    .go_i      (tx_go),
    .go_len_i  (tx_len),
    .rd_req    (tx_req),
    .rd_gnt    (tx_gnt),
    .rd_addr   (tx_addr),
    .rd_data   (ram_rdata),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .state_o   (tx_state)
  );

  // one RAM port, fixed priority: receive beat, transmit fetch, processor
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic          rx_beat;

  assign rx_beat = in_valid && in_ready;

  always_comb begin
    tx_gnt      = 1'b0;
    cpu_buf_gnt = 1'b0;
    ram_we      = 1'b0;
    ram_addr    = cpu_buf_addr;
    ram_wdata   = cpu_buf_wdata;
    if (rx_beat) begin
      ram_we    = rx_wr;
      ram_addr  = rx_addr;
      ram_wdata = rx_data;
    end else if (tx_req) begin
      tx_gnt    = 1'b1;
      ram_addr  = tx_addr;
    end else if (cpu_buf_req) begin
      cpu_buf_gnt = 1'b1;
      ram_we      = cpu_buf_we;
    end
  end

  pbh_buf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign cpu_buf_rdata = ram_rdata;

  // registered status word
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q             <= '0;
      status_q[ST_TX_IDLE] <= 1'b1;
    end else begin
      status_q                      <= '0;
      status_q[ST_RX_DONE]          <= (rx_state == SIDE_DONE);
      status_q[ST_RX_ERR]           <= (rx_state == SIDE_ERR);
      status_q[ST_RX_IDLE]          <= (rx_state == SIDE_IDLE);
      status_q[ST_TX_DONE]          <= (tx_state == SIDE_DONE);
      status_q[ST_TX_ERR]           <= (tx_state == SIDE_ERR);
      status_q[ST_TX_IDLE]          <= (tx_state == SIDE_IDLE);
      status_q[LEN_LSB +: LEN_W]    <= (rx_state == SIDE_DONE) ?
                                       {{(LEN_W-CW){1'b0}}, rx_len} : '0;
    end
  end

  p_one_owner_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_beat, tx_gnt, cpu_buf_gnt}));

  p_cpu_yields_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_beat || tx_req) |-> !cpu_buf_gnt);

  p_len_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !status_q[ST_RX_DONE] |-> (status_q[LEN_LSB +: LEN_W] == '0));

  p_rx_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(status_q[2:0]) <= 1);

  p_tx_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(status_q[6:4]) <= 1);

endmodule

// File: tb/test_pktbuf_hs.sv
module test_pktbuf_hs;

  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          ctrl_wr;
  logic [31:0]   ctrl_wdata;
  logic [31:0]   status_q;
  logic          cpu_buf_req, cpu_buf_we, cpu_buf_gnt;
  logic [AW-1:0] cpu_buf_addr;
  logic [DW-1:0] cpu_buf_wdata, cpu_buf_rdata;
  logic          in_valid, in_last, in_ready;
  logic [DW-1:0] in_data;
  logic          out_valid, out_last, out_ready;
  logic [DW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit saw_out;

  always #5 clk = ~clk;

  pktbuf_hs #(.DW(DW), .DEPTH(DEPTH)) i_pktbuf_hs (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .status_q(status_q),
    .cpu_buf_req(cpu_buf_req), .cpu_buf_we(cpu_buf_we),
    .cpu_buf_addr(cpu_buf_addr), .cpu_buf_wdata(cpu_buf_wdata),
    .cpu_buf_gnt(cpu_buf_gnt), .cpu_buf_rdata(cpu_buf_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );

  always @(negedge clk) if (out_valid) saw_out = 1'b1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctrl(input logic [31:0] v);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_wdata = '0;
    @(negedge clk);
  endtask

  task automatic buf_access(input logic we, input logic [AW-1:0] a,
                            input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cpu_buf_req = 1'b1; cpu_buf_we = we; cpu_buf_addr = a; cpu_buf_wdata = d;
    #1;
    while (!cpu_buf_gnt) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    q = cpu_buf_rdata;
    cpu_buf_req = 1'b0; cpu_buf_we = 1'b0;
  endtask

  task automatic rx_send(input int n, input logic [31:0] base,
                         input bit with_last, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!in_ready) begin
        in_valid = 1'b0; in_last = 1'b0;
        break;
      end
      in_valid = 1'b1; in_data = base + i; in_last = with_last && (i == n - 1);
      acc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic tx_collect(input int n, input logic [31:0] base);
    int i = 0;
    int guard = 0;
    bit pend = 1'b0;
    logic [31:0] pd = '0;
    logic pl = 1'b0;
    while (i < n && guard < 300) begin
      @(negedge clk);
      guard++;
      if (pend) begin
        chk("R10", "valid held under stall", {31'd0, out_valid}, 32'd1);
        chk("R10", "data held under stall", out_data, pd);
        chk("R10", "last held under stall", {31'd0, out_last}, {31'd0, pl});
      end
      out_ready = (guard % 3) != 0;
      pend = 1'b0;
      if (out_valid) begin
        if (out_ready) begin
          chk("R7", "out line data", out_data, base + i);
          chk("R7", "out_last position", {31'd0, out_last}, {31'd0, (i == n - 1)});
          i++;
        end else begin
          pend = 1'b1; pd = out_data; pl = out_last;
        end
      end
    end
    chk("R7", "lines delivered", i, n);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // scenarios ------------------------------------------------------------
  task automatic t_reset;
    chk("R1", "status after reset", status_q, 32'h0000_0040);
    chk("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_rx_packet;
    int acc;
    logic [31:0] q;
    rx_send(5, 32'hA000, 1'b1, acc);
    idle_cycles(2);
    chk("R3", "status after 5-line packet", status_q, 32'h0005_0041);
    chk("R3", "in_ready dropped when done", {31'd0, in_ready}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      buf_access(1'b0, AW'(k), '0, q);
      chk("R3", "received line content", q, 32'hA000 + k);
    end
  endtask

  task automatic t_rx_handshake;
    idle_cycles(5);
    chk("R5", "done sticky", status_q, 32'h0005_0041);
    ctrl(32'h0000_0002);
    chk("R6", "rx start while done ignored", status_q, 32'h0005_0041);
    ctrl(32'h0000_0001);
    chk("R5", "rx clear gives idle", status_q, 32'h0000_0044);
    ctrl(32'h0000_0001);
    chk("R6", "rx clear while idle no effect", status_q, 32'h0000_0044);
    chk("R6", "in_ready low while idle", {31'd0, in_ready}, 32'd0);
    ctrl(32'h0000_0002);
    chk("R2", "rx start rearms", status_q, 32'h0000_0040);
    chk("R2", "in_ready after rearm", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_rx_overflow;
    int acc;
    rx_send(DEPTH + 4, 32'hB000, 1'b0, acc);
    idle_cycles(2);
    chk("R4", "beats taken before overflow", acc, DEPTH + 1);
    chk("R4", "error status", status_q, 32'h0000_0042);
    chk("R4", "in_ready low after error", {31'd0, in_ready}, 32'd0);
    idle_cycles(4);
    chk("R5", "error sticky", status_q, 32'h0000_0042);
    ctrl(32'h0000_0001);
    chk("R5", "clear after error", status_q, 32'h0000_0044);
    ctrl(32'h0000_0002);
    chk("R4", "rearmed after error", status_q, 32'h0000_0040);
  endtask

  task automatic t_tx_packet;
    logic [31:0] q;
    for (int k = 0; k < 8; k++) buf_access(1'b1, AW'(k), 32'hC000 + k, q);
    ctrl(32'h0008_0008);
    tx_collect(8, 32'hC000);
    idle_cycles(2);
    chk("R7", "tx done status", status_q, 32'h0000_0010);
    saw_out = 1'b0;
    ctrl(32'h0008_0008);
    idle_cycles(4);
    chk("R6", "tx start while done ignored", status_q, 32'h0000_0010);
    chk("R6", "no beats after ignored start", {31'd0, saw_out}, 32'd0);
    ctrl(32'h0000_0004);
    chk("R5", "tx clear gives idle", status_q, 32'h0000_0040);
  endtask

  task automatic t_tx_errors;
    saw_out = 1'b0;
    ctrl(32'h0000_0008);
    idle_cycles(3);
    chk("R8", "zero count error", status_q, 32'h0000_0020);
    ctrl(32'h0000_0004);
    chk("R8", "clear after zero count", status_q, 32'h0000_0040);
    ctrl(32'h0011_0008);
    idle_cycles(3);
    chk("R8", "over-depth count error", status_q, 32'h0000_0020);
    chk("R8", "no beats on error", {31'd0, saw_out}, 32'd0);
    ctrl(32'h0000_0004);
    chk("R8", "clear after over-depth", status_q, 32'h0000_0040);
  endtask

  task automatic t_arbitration;
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hD00D; in_last = 1'b1;
    cpu_buf_req = 1'b1; cpu_buf_we = 1'b0; cpu_buf_addr = AW'(3);
    #1;
    chk("R9", "cpu blocked by rx beat", {31'd0, cpu_buf_gnt}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #1;
    chk("R9", "cpu granted after beat", {31'd0, cpu_buf_gnt}, 32'd1);
    @(negedge clk);
    chk("R9", "cpu read data next cycle", cpu_buf_rdata, 32'hC003);
    cpu_buf_req = 1'b0;
    idle_cycles(1);
    chk("R3", "one-line packet status", status_q, 32'h0001_0041);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; ctrl_wr = 1'b0; ctrl_wdata = '0;
    cpu_buf_req = 1'b0; cpu_buf_we = 1'b0; cpu_buf_addr = '0; cpu_buf_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b0;
    saw_out = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx_packet();
    t_rx_handshake();
    t_rx_overflow();
    t_tx_packet();
    t_tx_errors();
    t_arbitration();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule